// File: doc/BRIEF.md
# Operand Resolver with Pointer Side-Effects

This unit owns the eight 16-bit general registers of a small 16-bit processor and turns each instruction operand into either a register value or a memory access. An operand is a 3-bit register code with an indirection flag. In direct mode the unit reads or writes the register itself. In indirect mode it uses the register as a word address into a 65536-word memory, and three registers behave in a special way. The stack pointer (code 5) decrements before an indirect write and increments after an indirect read. The program counter (code 6) increments after any indirect access, so an indirect read of it yields the next inline word. The status word (code 7) is never used as an address: indirect use first reads an inline word at the program counter, advances the program counter, and then uses that word as the absolute address of the operand.

The sequencer hands over one operand at a time with a request strobe and a read/write direction. A small state machine moves through the states IDLE, FETCH_PTR, ACCESS and RESPOND. The transitions are: IDLE to RESPOND on a direct request, IDLE to FETCH_PTR on an indirect request through code 7, IDLE to ACCESS on any other indirect request, FETCH_PTR to ACCESS when the inline word is granted, ACCESS to RESPOND when the operand access is granted, and RESPOND back to IDLE unconditionally. Memory answers with a one-cycle grant and, for reads, data that is valid in the grant cycle. Pointer updates are committed in that grant cycle and are reported on a post-update strobe. The sequencer also has its own combinational read port and a write port into the register bank. The write port wins over any other change to the same register in the same cycle.

Top module: `opr_unit`

## Requirements
- R1: After reset all eight registers read as zero, so the interrupt-enable bit of the status word is 0, and `op_ready` is 1.
- R2: A direct read (`op_ind`=0, `op_wr`=0) accepted at a clock edge raises `op_done` for exactly the following cycle, with `op_rdata` equal to the value of register `op_reg` at acceptance, and makes no memory request.
- R3: A direct write (`op_ind`=0, `op_wr`=1) stores `op_wdata` into register `op_reg` at the accepting edge, makes no memory request, and raises `op_done` in the following cycle. This also applies to code 6, and later indirect uses of code 6 start from the written value.
- R4: An indirect operand through codes 0 to 4 makes exactly one memory access at the register's value. A read returns the memory word on `op_rdata`, a write stores `op_wdata` there, and no register changes.
- R5: An indirect read through code 5 reads the word at SP, and SP becomes SP+1 (modulo 2^16).
- R6: An indirect write through code 5 writes the word at SP-1, and SP becomes SP-1 (modulo 2^16, so 0 becomes 0xFFFF).
- R7: An indirect access through code 6 accesses the word at PC, and PC becomes PC+1.
- R8: An indirect access through code 7 first reads the word at PC and advances PC by one, then performs the operand access at the address given by that word. The status register is not changed.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr` and `mem_we` hold their values. Each access changes its pointer only once, in its grant cycle.
- R10: A write-port write (`wr_en`) stores `wr_data` into register `wr_idx` at the clock edge. It takes priority over a pointer update or a direct operand write to the same register in the same cycle. A pointer update to a different register still takes effect.
- R11: `rd_data` equals the current value of register `rd_idx`, combinationally.
- R12: `upd_en` is high only in a grant cycle of an access that changes a pointer, with `upd_idx` giving that pointer's code (5 or 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_req | input | 1 | Operand request strobe, taken when `op_ready` is 1 |
| op_wr | input | 1 | 1 = operand is written, 0 = operand is read |
| op_ind | input | 1 | Indirection flag |
| op_reg | input | 3 | Register code of the operand |
| op_wdata | input | 16 | Data to write for a write operand |
| op_ready | output | 1 | Unit is idle and accepts a request |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | 16 | Operand value of a read, valid with `op_done` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the grant cycle |
| mem_gnt | input | 1 | Memory grant, completes the current access |
| upd_en | output | 1 | Pointer post-update strobe |
| upd_idx | output | 3 | Code of the pointer being updated |
| rd_idx | input | 3 | Sequencer read-port register code |
| rd_data | output | 16 | Sequencer read-port value |
| wr_en | input | 1 | Sequencer write-port enable |
| wr_idx | input | 3 | Sequencer write-port register code |
| wr_data | input | 16 | Sequencer write-port data |

## Verification
The two functions that can fall into the same cycle are a pointer commit and a sequencer write-port write. The pointer commit is an SP or PC update on a memory grant. A direct operand write can also coincide with a write-port write at the accepting edge. The bench's memory model provokes the first case by raising the write port in exactly the cycle in which it issues the grant. This covers SP, PC, the PC advance of the status-word fetch, and an unrelated register. The bench then judges the outcome by sweeping all eight registers through the read port against its reference model. The write-port value must win on the shared register, and the pointer update must still land when the registers differ.

// File: rtl/opr_pkg.sv
`timescale 1ns/1ps
package opr_pkg;
    localparam int NREG = 8;
    localparam int IW   = $clog2(NREG);

    localparam logic [IW-1:0] IDX_SP  = 3'd5;
    localparam logic [IW-1:0] IDX_PC  = 3'd6;
    localparam logic [IW-1:0] IDX_PSW = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_PTR,
        ST_ACCESS,
        ST_RESPOND
    } opr_state_e;
endpackage

// File: rtl/opr_rf_bank.sv
`timescale 1ns/1ps
module opr_rf_bank
    import opr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IW-1:0]            rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [NREG-1:0][DW-1:0]  regs_o,
    input  logic                     sq_we,
    input  logic [IW-1:0]            sq_idx,
    input  logic [DW-1:0]            sq_data,
    input  logic                     op_we,
    input  logic [IW-1:0]            op_idx,
    input  logic [DW-1:0]            op_data,
    input  logic                     pu_en,
    input  logic [IW-1:0]            pu_idx,
    input  logic [DW-1:0]            pu_val
);
    logic [DW-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [IW-1:0] MY_IDX = IW'(g);

        // sequencer port > direct operand write > pointer update
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (sq_we && sq_idx == MY_IDX)
                regs_q[g] <= sq_data;
            else if (op_we && op_idx == MY_IDX)
                regs_q[g] <= op_data;
            else if (pu_en && pu_idx == MY_IDX)
                regs_q[g] <= pu_val;
        end

        assign regs_o[g] = regs_q[g];
    end

    assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/opr_addr_gen.sv
`timescale 1ns/1ps
module opr_addr_gen
    import opr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [IW-1:0] code,
    input  logic          wr,
    input  logic [DW-1:0] cur_val,
    input  logic [DW-1:0] sp_val,
    input  logic [DW-1:0] pc_val,
    output logic [DW-1:0] first_addr,
    output logic          need_fetch,
    output logic          pu_en,
    output logic [IW-1:0] pu_idx,
    output logic [DW-1:0] pu_val
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        first_addr = cur_val;
        need_fetch = 1'b0;
        pu_en      = 1'b0;
        pu_idx     = code;
        pu_val     = cur_val;
        unique case (code)
            IDX_SP: begin
                pu_en = 1'b1;
                if (wr) begin
                    first_addr = sp_val - ONE;
                    pu_val     = sp_val - ONE;
                end else begin
                    first_addr = sp_val;
                    pu_val     = sp_val + ONE;
                end
            end
            IDX_PC: begin
                pu_en      = 1'b1;
                first_addr = pc_val;
                pu_val     = pc_val + ONE;
            end
            IDX_PSW: begin
                need_fetch = 1'b1;
                pu_en      = 1'b1;
                pu_idx     = IDX_PC;
                first_addr = pc_val;
                pu_val     = pc_val + ONE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opr_unit.sv
`timescale 1ns/1ps
module opr_unit
    import opr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_req,
    input  logic          op_wr,
    input  logic          op_ind,
    input  logic [2:0]    op_reg,
    input  logic [DW-1:0] op_wdata,
    output logic          op_ready,
    output logic          op_done,
    output logic [DW-1:0] op_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_gnt,
    output logic          upd_en,
    output logic [2:0]    upd_idx,
    input  logic [2:0]    rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [2:0]    wr_idx,
    input  logic [DW-1:0] wr_data
);
    opr_state_e state_q, state_d;

    logic [NREG-1:0][DW-1:0] regs_w;
    logic [DW-1:0] addr_q, wdata_q, res_q, puval_q;
    logic          wr_q, puen_q;
    logic [IW-1:0] puidx_q;

    logic [DW-1:0] ag_addr, ag_val;
    logic          ag_fetch, ag_en;
    logic [IW-1:0] ag_idx;

    logic accept, in_mem, commit, dir_we;

    opr_addr_gen #(.DW(DW)) u_agen (
        .code       (op_reg),
        .wr         (op_wr),
        .cur_val    (regs_w[op_reg]),
        .sp_val     (regs_w[IDX_SP]),
        .pc_val     (regs_w[IDX_PC]),
        .first_addr (ag_addr),
        .need_fetch (ag_fetch),
        .pu_en      (ag_en),
        .pu_idx     (ag_idx),
        .pu_val     (ag_val)
    );

    assign accept = op_req && (state_q == ST_IDLE);
    assign in_mem = (state_q == ST_FETCH_PTR) || (state_q == ST_ACCESS);
    assign commit = in_mem && mem_gnt && puen_q;
    assign dir_we = accept && !op_ind && op_wr;

    opr_rf_bank #(.DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_w),
        .sq_we   (wr_en),
        .sq_idx  (wr_idx),
        .sq_data (wr_data),
        .op_we   (dir_we),
        .op_idx  (op_reg),
        .op_data (op_wdata),
        .pu_en   (commit),
        .pu_idx  (puidx_q),
        .pu_val  (puval_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_req) begin
                    if (!op_ind)       state_d = ST_RESPOND;
                    else if (ag_fetch) state_d = ST_FETCH_PTR;
                    else               state_d = ST_ACCESS;
                end
            end
            ST_FETCH_PTR: if (mem_gnt) state_d = ST_ACCESS;
            ST_ACCESS:    if (mem_gnt) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // operand context captured along the way
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
            wr_q    <= 1'b0;
            puen_q  <= 1'b0;
            puidx_q <= '0;
            puval_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        wr_q    <= op_wr;
                        wdata_q <= op_wdata;
                        if (!op_ind) begin
                            res_q  <= op_wr ? op_wdata : regs_w[op_reg];
                            puen_q <= 1'b0;
                        end else begin
                            addr_q  <= ag_addr;
                            puen_q  <= ag_en;
                            puidx_q <= ag_idx;
                            puval_q <= ag_val;
                        end
                    end
                end
                ST_FETCH_PTR: begin
                    if (mem_gnt) begin
                        addr_q <= mem_rdata;
                        puen_q <= 1'b0;
                    end
                end
                ST_ACCESS: begin
                    if (mem_gnt && !wr_q) res_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        op_ready  = (state_q == ST_IDLE);
        op_done   = (state_q == ST_RESPOND);
        op_rdata  = res_q;
        mem_req   = in_mem;
        mem_we    = (state_q == ST_ACCESS) && wr_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        upd_en    = commit;
        upd_idx   = puidx_q;
    end
endmodule

// File: rtl/opr_unit_chk.sv
`timescale 1ns/1ps
module opr_unit_chk
    import opr_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    op_ready,
    input logic                    op_done,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [DW-1:0]           mem_addr,
    input logic                    mem_gnt,
    input logic                    upd_en,
    input logic [2:0]              upd_idx,
    input logic                    wr_en,
    input logic [2:0]              wr_idx,
    input logic [DW-1:0]           wr_data,
    input logic [NREG-1:0][DW-1:0] regs
);
    localparam logic [DW-1:0] ONE = DW'(1);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done && op_ready); // R2

    AST_SP_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_idx == IDX_SP && !mem_we) |-> mem_addr == regs[IDX_SP]); // R5

    AST_SP_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_idx == IDX_SP && mem_we) |-> mem_addr == regs[IDX_SP] - ONE); // R6

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_idx == IDX_PC && !(wr_en && wr_idx == IDX_PC))
        |=> regs[IDX_PC] == $past(regs[IDX_PC]) + ONE); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

    AST_SEQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data)); // R10

    AST_UPD_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> mem_gnt && mem_req && (upd_idx == IDX_SP || upd_idx == IDX_PC)); // R12
endmodule

bind opr_unit opr_unit_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_ready (op_ready),
    .op_done  (op_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_gnt  (mem_gnt),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .regs     (regs_w)
);

// File: tb/tb_opr_unit.sv
`timescale 1ns/1ps
module tb_opr_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        op_req = 0, op_wr = 0, op_ind = 0;
    logic [2:0]  op_reg = 0;
    logic [15:0] op_wdata = 0;
    logic        op_ready, op_done;
    logic [15:0] op_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 0;
    logic        mem_gnt = 0;
    logic        upd_en;
    logic [2:0]  upd_idx;
    logic [2:0]  rd_idx = 0;
    logic [15:0] rd_data;
    logic        sq_en = 0, cw_en = 0;
    logic [2:0]  sq_idx = 0, cw_idx = 0;
    logic [15:0] sq_data = 0, cw_data = 0;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [15:0] wr_data;

    assign wr_en   = sq_en | cw_en;
    assign wr_idx  = cw_en ? cw_idx : sq_idx;
    assign wr_data = cw_en ? cw_data : sq_data;

    opr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .op_req(op_req), .op_wr(op_wr), .op_ind(op_ind), .op_reg(op_reg), .op_wdata(op_wdata),
        .op_ready(op_ready), .op_done(op_done), .op_rdata(op_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .upd_en(upd_en), .upd_idx(upd_idx),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    int tests = 0, fails = 0, cyc = 0;

    typedef struct {
        logic [15:0] a;
        logic        we;
        logic [15:0] d;
        logic        upd;
        logic [2:0]  ui;
    } acc_t;

    acc_t        xq[$];
    logic [15:0] mem [int];
    logic [15:0] mr [8];
    int          lat = 0, wcnt = 0;
    logic        col_armed = 0, held = 0;
    logic [2:0]  col_idx = 0;
    logic [15:0] col_data = 0, held_addr = 0;
    string       cur_tag = "R1";

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    // memory model: grant after 'lat' waiting cycles, checks each access
    always @(negedge clk) begin
        if (mem_gnt) begin
            mem_gnt = 1'b0;
            cw_en   = 1'b0;
            wcnt    = 0;
        end else if (mem_req) begin
            if (held)
                chk(mem_addr == held_addr, "R9", mem_addr, held_addr);
            if (wcnt < lat) begin
                wcnt++;
                held = 1'b1;
                held_addr = mem_addr;
            end else begin
                held = 1'b0;
                if (xq.size() == 0) begin
                    chk(1'b0, "R4", mem_addr, 16'hxxxx);
                end else begin
                    acc_t e;
                    e = xq.pop_front();
                    chk(mem_addr == e.a, cur_tag, mem_addr, e.a);
                    chk(mem_we == e.we, cur_tag, 16'(mem_we), 16'(e.we));
                    if (mem_we) begin
                        chk(mem_wdata == e.d, cur_tag, mem_wdata, e.d);
                        mem[int'(mem_addr)] = mem_wdata;
                    end else begin
                        mem_rdata = rd(mem_addr);
                    end
                    mem_gnt = 1'b1;
                    if (e.upd && col_armed) begin
                        cw_en = 1'b1; cw_idx = col_idx; cw_data = col_data;
                        col_armed = 1'b0;
                    end
                    #1;
                    chk(upd_en == e.upd, "R12", 16'(upd_en), 16'(e.upd));
                    if (e.upd) chk(upd_idx == e.ui, "R12", 16'(upd_idx), 16'(e.ui));
                end
            end
        end else if (upd_en) begin
            chk(1'b0, "R12", 16'(upd_en), 16'h0);
        end
    end

    task automatic sweep(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.2;
            chk(rd_data == mr[i], req, rd_data, mr[i]);
        end
    endtask

    task automatic seqw(input logic [2:0] idx, input logic [15:0] v);
        @(negedge clk);
        sq_en = 1'b1; sq_idx = idx; sq_data = v;
        @(negedge clk);
        sq_en = 1'b0;
        mr[idx] = v;
        sweep("R10");
    endtask

    task automatic push(input logic [15:0] a, input logic we, input logic [15:0] d,
                        input logic upd, input logic [2:0] ui);
        acc_t e;
        e.a = a; e.we = we; e.d = d; e.upd = upd; e.ui = ui;
        xq.push_back(e);
    endtask

    task automatic do_op(input logic ind, input logic wr, input logic [2:0] code,
                         input logic [15:0] wd, input int lat_i, input logic col,
                         input logic [2:0] cidx, input logic [15:0] cdata, input string tag);
        logic [15:0] exp_r, a;
        int n;
        @(negedge clk);
        chk(op_ready == 1'b1, tag, 16'(op_ready), 16'h1);
        cur_tag = tag;
        exp_r = 16'h0;
        lat = lat_i;
        if (!ind) begin
            if (wr) mr[code] = wd; else exp_r = mr[code];
            if (col) begin
                sq_en = 1'b1; sq_idx = cidx; sq_data = cdata;
                mr[cidx] = cdata;
            end
        end else begin
            unique case (code)
                3'd5: begin
                    if (wr) begin
                        mr[5] = mr[5] - 16'd1;
                        push(mr[5], 1'b1, wd, 1'b1, 3'd5);
                    end else begin
                        push(mr[5], 1'b0, 16'h0, 1'b1, 3'd5);
                        exp_r = rd(mr[5]);
                        mr[5] = mr[5] + 16'd1;
                    end
                end
                3'd6: begin
                    push(mr[6], wr, wd, 1'b1, 3'd6);
                    exp_r = rd(mr[6]);
                    mr[6] = mr[6] + 16'd1;
                end
                3'd7: begin
                    push(mr[6], 1'b0, 16'h0, 1'b1, 3'd6);
                    a = rd(mr[6]);
                    mr[6] = mr[6] + 16'd1;
                    push(a, wr, wd, 1'b0, 3'd0);
                    exp_r = rd(a);
                end
                default: begin
                    push(mr[code], wr, wd, 1'b0, 3'd0);
                    exp_r = rd(mr[code]);
                end
            endcase
            if (col) begin
                col_armed = 1'b1; col_idx = cidx; col_data = cdata;
                mr[cidx] = cdata;
            end
        end
        op_req = 1'b1; op_wr = wr; op_ind = ind; op_reg = code; op_wdata = wd;
        @(negedge clk);
        op_req = 1'b0; sq_en = 1'b0;
        if (!ind)
            chk(op_done == 1'b1, tag, 16'(op_done), 16'h1);
        n = 0;
        while (!op_done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(op_done == 1'b1, tag, 16'(op_done), 16'h1);
        if (!wr) chk(op_rdata == exp_r, tag, op_rdata, exp_r);
        chk(xq.size() == 0, tag, 16'(xq.size()), 16'h0);
        sweep(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL R9: watchdog expired, actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mr[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready == 1'b1, "R1", 16'(op_ready), 16'h1);
        sweep("R1");    // status word and its interrupt-enable bit are zero

        // R10 / R11: sequencer port loads and read-back
        seqw(3'd1, 16'h0010);
        seqw(3'd2, 16'h0020);
        seqw(3'd3, 16'hA5A5);
        seqw(3'd4, 16'h7777);

        do_op(0, 0, 3'd3, 16'h0, 0, 0, 3'd0, 16'h0, "R2");
        do_op(0, 1, 3'd2, 16'h0030, 0, 0, 3'd0, 16'h0, "R3");

        // R4: plain indirect
        mem[32'h10] = 16'hCAFE;
        do_op(1, 0, 3'd1, 16'h0, 2, 0, 3'd0, 16'h0, "R4");
        do_op(1, 1, 3'd2, 16'h5555, 0, 0, 3'd0, 16'h0, "R4");
        do_op(1, 0, 3'd2, 16'h0, 1, 0, 3'd0, 16'h0, "R4");

        // R6 then R5: push two, pop two (LIFO)
        seqw(3'd5, 16'h0100);
        do_op(1, 1, 3'd5, 16'h1111, 1, 0, 3'd0, 16'h0, "R6");
        do_op(1, 1, 3'd5, 16'h2222, 0, 0, 3'd0, 16'h0, "R6");
        do_op(1, 0, 3'd5, 16'h0, 3, 0, 3'd0, 16'h0, "R5");
        do_op(1, 0, 3'd5, 16'h0, 0, 0, 3'd0, 16'h0, "R5");

        // R7: inline words through PC
        seqw(3'd6, 16'h0040);
        mem[32'h40] = 16'h1234; mem[32'h41] = 16'h4321;
        do_op(1, 0, 3'd6, 16'h0, 0, 0, 3'd0, 16'h0, "R7");
        do_op(1, 0, 3'd6, 16'h0, 2, 0, 3'd0, 16'h0, "R7");

        // R8: absolute addressing through an inline word
        mem[32'h42] = 16'h0200; mem[32'h200] = 16'hBEEF; mem[32'h43] = 16'h0201;
        do_op(1, 0, 3'd7, 16'h0, 1, 0, 3'd0, 16'h0, "R8");
        do_op(1, 1, 3'd7, 16'h9999, 3, 0, 3'd0, 16'h0, "R8");
        seqw(3'd4, 16'h0201);
        do_op(1, 0, 3'd4, 16'h0, 0, 0, 3'd0, 16'h0, "R8");

        // R10: write port collides with pointer commits
        mem[32'h100] = 16'h0B0B;
        do_op(1, 0, 3'd5, 16'h0, 1, 1, 3'd5, 16'h0500, "R10");
        do_op(1, 0, 3'd6, 16'h0, 0, 1, 3'd6, 16'h0800, "R10");
        mem[32'h800] = 16'h0300; mem[32'h300] = 16'h0ABC;
        do_op(1, 0, 3'd7, 16'h0, 2, 1, 3'd6, 16'h0900, "R10");
        do_op(1, 1, 3'd5, 16'h3C3C, 0, 1, 3'd3, 16'h3333, "R10");
        do_op(0, 1, 3'd2, 16'h1234, 0, 1, 3'd2, 16'h4444, "R10");

        // R6 / R5: stack pointer wrap at zero
        seqw(3'd5, 16'h0000);
        do_op(1, 1, 3'd5, 16'h7E7E, 1, 0, 3'd0, 16'h0, "R6");
        do_op(1, 0, 3'd5, 16'h0, 0, 0, 3'd0, 16'h0, "R5");

        // R3: direct PC write steers the next inline read
        do_op(0, 1, 3'd6, 16'h0050, 0, 0, 3'd0, 16'h0, "R3");
        mem[32'h50] = 16'h5050;
        do_op(1, 0, 3'd6, 16'h0, 1, 0, 3'd0, 16'h0, "R7");

        // R8: status word written directly is not an address
        do_op(0, 1, 3'd7, 16'h00F0, 0, 0, 3'd0, 16'h0, "R3");
        mem[32'h51] = 16'h0010;
        do_op(1, 0, 3'd7, 16'h0, 0, 0, 3'd0, 16'h0, "R8");
        do_op(0, 0, 3'd7, 16'h0, 0, 0, 3'd0, 16'h0, "R2");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule